// File: doc/BRIEF.md
# USB Device Interrupt Enable and Status Bank

This block holds the interrupt state of a USB device controller. Event pulses from the endpoint and bus logic latch into two 8-bit status registers. Two 8-bit enable registers decide which latched events reach the single CPU interrupt line. The CPU reads and writes the four registers through a small synchronous port. Each status bit stays set until the CPU writes a 1 to it.

The first status register also shows a read-only summary bit. It is set whenever any bit of the second status register is set, so a handler can test one register first and read the second only when it must. The upper bits of the second enable register are interrupt enables. Its low three bits select the data-toggle behaviour of the three non-control data endpoints, and they are driven straight out to the transaction logic. The EP2 toggle-mode bit also changes how EP2 completions are counted as events.

Top module: `usb_irq_bank`

## Requirements
- R1: Register select `cpu_addr` maps 0 to enable register 1, 1 to enable register 2, 2 to status register 1 and 3 to status register 2. `cpu_rdata` shows the selected register combinationally. A write with `cpu_wr` high takes effect on the rising clock edge.
- R2: A high pulse sampled at a rising edge sets a bit of status register 1. The bits are: 7 EP4 packet sent, 6 EP3 packet received, 5 EP2 event (see R12), 4 EP4 watermark, 3 EP3 watermark, 2 SETUP received.
- R3: A high pulse sampled at a rising edge sets a bit of status register 2. The bits are: 7 EP0 transmit done, 6 EP0 receive done, 5 EP0 error, 4 bus reset, 3 suspend, 2 start of frame.
- R4: Writing to a status register clears every bit written as 1. Bits written as 0 keep their value.
- R5: If an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: Bit 1 of status register 1 reads as the OR of all bits of status register 2. Writes to that bit have no effect.
- R7: Reset (synchronous, active high) clears all four registers and holds `irq` low.
- R8: Reserved bits read 0 and ignore writes. These are status register 1 bit 0, status register 2 bits 1:0, and enable register 2 bit 3.
- R9: The enable bits map to status bits as follows:
  - Enable register 1 bits 7:2 gate status register 1 bits 7:2.
  - Enable register 1 bit 1 gates EP0 transmit (status 2 bit 7), and bit 0 gates EP0 receive (status 2 bit 6).
  - Enable register 2 bit 7 gates EP0 error, bit 6 gates bus reset, bit 5 gates start of frame, and bit 4 gates suspend.
- R10: `irq` is high exactly when some status bit is set and its enable bit is set. It follows the registers combinationally, and the summary bit is not a separate source.
- R11: Enable register 2 bits 2, 1 and 0 drive `toggle_mode[2]` (EP4), `toggle_mode[1]` (EP3) and `toggle_mode[0]` (EP2). A 1 means the toggle returns to 0 after every transaction. A 0 means the toggle flips on every successful transaction.
- R12: With `toggle_mode[0]` at 0, an EP2 transaction pulse sets status register 1 bit 5 only when `evt_ep2_ack` is high in the same cycle. With it at 1, every EP2 transaction pulse sets the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register select |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of selected register |
| evt_ep4_sent | input | 1 | EP4 bulk packet sent pulse |
| evt_ep3_rcvd | input | 1 | EP3 bulk packet received pulse |
| evt_ep2_txn | input | 1 | EP2 transaction finished pulse |
| evt_ep2_ack | input | 1 | Host acknowledged the EP2 transaction |
| evt_ep4_wm | input | 1 | EP4 FIFO watermark pulse |
| evt_ep3_wm | input | 1 | EP3 FIFO watermark pulse |
| evt_setup | input | 1 | SETUP packet received pulse |
| evt_ep0_tx | input | 1 | EP0 packet sent pulse |
| evt_ep0_rx | input | 1 | EP0 packet received pulse |
| evt_ep0_err | input | 1 | EP0 error pulse |
| evt_bus_rst | input | 1 | Bus reset detected pulse |
| evt_suspend | input | 1 | Suspend detected pulse |
| evt_sof | input | 1 | Start of frame pulse |
| toggle_mode | output | 3 | Data-toggle modes for EP4, EP3, EP2 |
| irq | output | 1 | CPU interrupt request |

## Verification
Event pulses and CPU writes act on the rising edge that samples them, so registers, `cpu_rdata`, `irq` and `toggle_mode` all show the result one edge after the stimulus, with no further latency. The bench drives each stimulus for exactly one rising edge and advances its reference model at that edge. After the following falling edge it walks `cpu_addr` through all four registers and compares the read data, `irq` and `toggle_mode` against the model. Collision, reserved-bit, summary-write and EP2 qualification cases are exercised directly, then a seeded random stream mixes events and writes.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;
    localparam int EVT_W  = 6;
    localparam int TGL_W  = 3;
    localparam int SUM_BIT = 1;

    typedef enum logic [ADDR_W-1:0] {
        RA_EN1 = 2'd0,
        RA_EN2 = 2'd1,
        RA_ST1 = 2'd2,
        RA_ST2 = 2'd3
    } reg_addr_e;

    // writable / settable bits of each register
    localparam logic [REG_W-1:0] EN1_VALID = 8'hFF;
    localparam logic [REG_W-1:0] EN2_VALID = 8'hF7;
    localparam logic [REG_W-1:0] ST1_VALID = 8'hFC;
    localparam logic [REG_W-1:0] ST2_VALID = 8'hFC;

    // field order equals status bit order 7 downto 2
    typedef struct packed {
        logic ep4_sent;
        logic ep3_rcvd;
        logic ep2_done;
        logic ep4_wm;
        logic ep3_wm;
        logic setup;
    } grp1_evt_t;

    typedef struct packed {
        logic ep0_tx;
        logic ep0_rx;
        logic ep0_err;
        logic bus_rst;
        logic suspend;
        logic sof;
    } grp2_evt_t;

    typedef struct packed {
        logic ep4;
        logic ep3;
        logic ep2;
    } tgl_mode_t;

    function automatic logic [REG_W-1:0] grp1_bits(input grp1_evt_t e);
        return {e, 2'b00};
    endfunction

    function automatic logic [REG_W-1:0] grp2_bits(input grp2_evt_t e);
        return {e, 2'b00};
    endfunction

    // enables aligned to status register 2 bit positions
    function automatic logic [REG_W-1:0] st2_gate(input logic [1:0] en1_lo,
                                                  input logic [3:0] en2_hi);
        // en2_hi = enable2[7:4]: [3] ep0 err, [2] bus rst, [1] sof, [0] suspend
        return {en1_lo[1], en1_lo[0], en2_hi[3], en2_hi[2], en2_hi[0], en2_hi[1], 2'b00};
    endfunction

endpackage

// File: rtl/usb_irq_enable_reg.sv
module usb_irq_enable_reg #(
    parameter int W = 8,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr)
            q <= wdata & VALID;
    end
endmodule

// File: rtl/usb_irq_w1c_reg.sv
module usb_irq_w1c_reg #(
    parameter int W = 8,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    // a set in the same cycle as a clear leaves the bit set
    always_comb begin
        nxt = ((q & ~clr_vec) | set_vec) & VALID;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= nxt;
    end
endmodule

// File: rtl/usb_irq_ep2_qual.sv
module usb_irq_ep2_qual (
    input  logic txn,
    input  logic ack,
    input  logic every_txn,
    output logic set_evt
);
    always_comb begin
        set_evt = txn & (every_txn | ack);
    end
endmodule

// File: rtl/usb_irq_combiner.sv
module usb_irq_combiner
    import usb_irq_pkg::*;
(
    input  logic [REG_W-1:0] st1,
    input  logic [REG_W-1:0] st2,
    input  logic [REG_W-1:0] en1,
    input  logic [3:0]       en2_hi,
    output logic             summary,
    output logic             irq
);
    logic [REG_W-1:0] g1;
    logic [REG_W-1:0] g2;

    always_comb begin
        g1      = {en1[7:2], 2'b00};
        g2      = st2_gate(en1[1:0], en2_hi);
        summary = |st2;
        irq     = (|(st1 & g1)) | (|(st2 & g2));
    end
endmodule

// File: rtl/usb_irq_bank.sv
module usb_irq_bank
    import usb_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  cpu_rdata,
    input  logic              evt_ep4_sent,
    input  logic              evt_ep3_rcvd,
    input  logic              evt_ep2_txn,
    input  logic              evt_ep2_ack,
    input  logic              evt_ep4_wm,
    input  logic              evt_ep3_wm,
    input  logic              evt_setup,
    input  logic              evt_ep0_tx,
    input  logic              evt_ep0_rx,
    input  logic              evt_ep0_err,
    input  logic              evt_bus_rst,
    input  logic              evt_suspend,
    input  logic              evt_sof,
    output logic [TGL_W-1:0]  toggle_mode,
    output logic              irq
);
    reg_addr_e        sel;
    logic             wr_en1, wr_en2, wr_st1, wr_st2;
    logic [REG_W-1:0] en1_q, en2_q, st1_q, st2_q;
    logic [REG_W-1:0] set1, set2, clr1, clr2;
    logic             ep2_set;
    logic             summary;
    grp1_evt_t        g1_evt;
    grp2_evt_t        g2_evt;
    tgl_mode_t        tgl;

    always_comb begin
        sel    = reg_addr_e'(cpu_addr);
        wr_en1 = cpu_wr && (sel == RA_EN1);
        wr_en2 = cpu_wr && (sel == RA_EN2);
        wr_st1 = cpu_wr && (sel == RA_ST1);
        wr_st2 = cpu_wr && (sel == RA_ST2);
        clr1   = wr_st1 ? cpu_wdata : '0;
        clr2   = wr_st2 ? cpu_wdata : '0;
    end

    always_comb begin
        tgl = tgl_mode_t'(en2_q[TGL_W-1:0]);
        toggle_mode = tgl;
    end

    usb_irq_ep2_qual u_ep2 (
        .txn       (evt_ep2_txn),
        .ack       (evt_ep2_ack),
        .every_txn (tgl.ep2),
        .set_evt   (ep2_set)
    );

    always_comb begin
        g1_evt = '{ep4_sent: evt_ep4_sent, ep3_rcvd: evt_ep3_rcvd, ep2_done: ep2_set,
                   ep4_wm: evt_ep4_wm, ep3_wm: evt_ep3_wm, setup: evt_setup};
        g2_evt = '{ep0_tx: evt_ep0_tx, ep0_rx: evt_ep0_rx, ep0_err: evt_ep0_err,
                   bus_rst: evt_bus_rst, suspend: evt_suspend, sof: evt_sof};
        set1   = grp1_bits(g1_evt);
        set2   = grp2_bits(g2_evt);
    end

    usb_irq_enable_reg #(.W(REG_W), .VALID(EN1_VALID)) u_en1 (
        .clk(clk), .rst(rst), .wr(wr_en1), .wdata(cpu_wdata), .q(en1_q)
    );
    usb_irq_enable_reg #(.W(REG_W), .VALID(EN2_VALID)) u_en2 (
        .clk(clk), .rst(rst), .wr(wr_en2), .wdata(cpu_wdata), .q(en2_q)
    );
    usb_irq_w1c_reg #(.W(REG_W), .VALID(ST1_VALID)) u_st1 (
        .clk(clk), .rst(rst), .set_vec(set1), .clr_vec(clr1), .q(st1_q)
    );
    usb_irq_w1c_reg #(.W(REG_W), .VALID(ST2_VALID)) u_st2 (
        .clk(clk), .rst(rst), .set_vec(set2), .clr_vec(clr2), .q(st2_q)
    );

    usb_irq_combiner u_comb (
        .st1     (st1_q),
        .st2     (st2_q),
        .en1     (en1_q),
        .en2_hi  (en2_q[7:4]),
        .summary (summary),
        .irq     (irq)
    );

    always_comb begin
        unique case (sel)
            RA_EN1:  cpu_rdata = en1_q;
            RA_EN2:  cpu_rdata = en2_q;
            RA_ST1: begin
                cpu_rdata          = st1_q;
                cpu_rdata[SUM_BIT] = summary;
            end
            default: cpu_rdata = st2_q;
        endcase
    end
endmodule

// File: rtl/usb_irq_bank_chk.sv
module usb_irq_bank_chk (
    input logic       clk,
    input logic       rst,
    input logic       cpu_wr,
    input logic [1:0] cpu_addr,
    input logic [7:0] cpu_wdata,
    input logic [7:0] cpu_rdata,
    input logic       evt_ep4_sent,
    input logic       evt_ep3_rcvd,
    input logic       evt_ep2_txn,
    input logic       evt_ep2_ack,
    input logic       evt_ep4_wm,
    input logic       evt_ep3_wm,
    input logic       evt_setup,
    input logic       evt_sof,
    input logic [2:0] toggle_mode,
    input logic       irq,
    input logic [7:0] st1_q,
    input logic [7:0] st2_q
);
    logic no_st1_evt;
    always_comb begin
        no_st1_evt = !(evt_ep4_sent || evt_ep3_rcvd || evt_ep2_txn ||
                       evt_ep4_wm || evt_ep3_wm || evt_setup);
    end

    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st1_q == 8'h00 && st2_q == 8'h00 && !irq));

    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == 2'd2 && no_st1_evt) |=> ((st1_q & $past(cpu_wdata)) == 8'h00));

    assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (rst)
        evt_setup |=> st1_q[2]);

    assert_sof_latched_R3: assert property (@(posedge clk) disable iff (rst)
        evt_sof |=> st2_q[2]);

    assert_summary_bit_R6: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr == 2'd2) |-> (cpu_rdata[1] == (|st2_q)));

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr == 2'd3) |-> (cpu_rdata[1:0] == 2'b00));

    assert_en2_reserved_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr == 2'd1) |-> !cpu_rdata[3]);

    assert_quiet_no_irq_R10: assert property (@(posedge clk) disable iff (rst)
        (st1_q == 8'h00 && st2_q == 8'h00) |-> !irq);

    assert_toggle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(cpu_wr && cpu_addr == 2'd1) |-> $stable(toggle_mode));

    assert_ep2_needs_ack_R12: assert property (@(posedge clk) disable iff (rst)
        (evt_ep2_txn && !evt_ep2_ack && !toggle_mode[0] && !st1_q[5]) |=> !st1_q[5]);
endmodule

bind usb_irq_bank usb_irq_bank_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_wr       (cpu_wr),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_rdata    (cpu_rdata),
    .evt_ep4_sent (evt_ep4_sent),
    .evt_ep3_rcvd (evt_ep3_rcvd),
    .evt_ep2_txn  (evt_ep2_txn),
    .evt_ep2_ack  (evt_ep2_ack),
    .evt_ep4_wm   (evt_ep4_wm),
    .evt_ep3_wm   (evt_ep3_wm),
    .evt_setup    (evt_setup),
    .evt_sof      (evt_sof),
    .toggle_mode  (toggle_mode),
    .irq          (irq),
    .st1_q        (st1_q),
    .st2_q        (st2_q)
);

// File: tb/usb_irq_bank_tb.sv
`timescale 1ns/1ps
module usb_irq_bank_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_wr = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic [12:0] ev = '0;
    logic [2:0] toggle_mode;
    logic       irq;

    // reference model state
    logic [7:0] m_en1 = 0, m_en2 = 0, m_s1 = 0, m_s2 = 0;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    usb_irq_bank u_dut (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .evt_ep4_sent(ev[12]), .evt_ep3_rcvd(ev[11]), .evt_ep2_txn(ev[10]),
        .evt_ep2_ack(ev[9]), .evt_ep4_wm(ev[8]), .evt_ep3_wm(ev[7]),
        .evt_setup(ev[6]), .evt_ep0_tx(ev[5]), .evt_ep0_rx(ev[4]),
        .evt_ep0_err(ev[3]), .evt_bus_rst(ev[2]), .evt_suspend(ev[1]),
        .evt_sof(ev[0]), .toggle_mode(toggle_mode), .irq(irq)
    );

    // event index constants
    localparam int E_EP4S = 12, E_EP3R = 11, E_EP2T = 10, E_EP2A = 9, E_EP4W = 8,
                   E_EP3W = 7, E_SETUP = 6, E_TX = 5, E_RX = 4, E_ERR = 3,
                   E_BRST = 2, E_SUSP = 1, E_SOF = 0;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_irq();
        logic [7:0] g2;
        g2 = {m_en1[1], m_en1[0], m_en2[7], m_en2[6], m_en2[4], m_en2[5], 2'b00};
        return (|(m_s1 & {m_en1[7:2], 2'b00})) | (|(m_s2 & g2));
    endfunction

    // one rising edge of stimulus; model advanced with pre-edge state
    task automatic step(input logic wr, input logic [1:0] a, input logic [7:0] d,
                        input logic [12:0] e);
        logic ep2set;
        logic [7:0] s1set, s2set, c1, c2, n1, n2, ne1, ne2;
        cpu_wr = wr; cpu_addr = a; cpu_wdata = d; ev = e;
        @(posedge clk);
        ep2set = e[E_EP2T] & (m_en2[0] | e[E_EP2A]);
        s1set = {e[E_EP4S], e[E_EP3R], ep2set, e[E_EP4W], e[E_EP3W], e[E_SETUP], 2'b00};
        s2set = {e[E_TX], e[E_RX], e[E_ERR], e[E_BRST], e[E_SUSP], e[E_SOF], 2'b00};
        c1 = (wr && a == 2'd2) ? d : 8'h00;
        c2 = (wr && a == 2'd3) ? d : 8'h00;
        n1 = ((m_s1 & ~c1) | s1set) & 8'hFC;
        n2 = ((m_s2 & ~c2) | s2set) & 8'hFC;
        ne1 = (wr && a == 2'd0) ? d : m_en1;
        ne2 = (wr && a == 2'd1) ? (d & 8'hF7) : m_en2;
        m_s1 = n1; m_s2 = n2; m_en1 = ne1; m_en2 = ne2;
        @(negedge clk);
        cpu_wr = 1'b0; ev = '0;
    endtask

    task automatic check_all(input string tag);
        cpu_wr = 1'b0;
        cpu_addr = 2'd0; #0.5; chk({tag, " en1"}, cpu_rdata, m_en1);
        cpu_addr = 2'd1; #0.5; chk({tag, " en2"}, cpu_rdata, m_en2);
        cpu_addr = 2'd2; #0.5; chk({tag, " st1"}, cpu_rdata, {m_s1[7:2], |m_s2, 1'b0});
        cpu_addr = 2'd3; #0.5; chk({tag, " st2"}, cpu_rdata, m_s2);
        chk({tag, " irq"}, {7'd0, irq}, {7'd0, exp_irq()});
        chk({tag, " toggle"}, {5'd0, toggle_mode}, {5'd0, m_en2[2:0]});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R7: everything zero after reset
        check_all("R7");

        // R2/R3: each event alone, enables off so irq stays low
        for (int i = 0; i < 13; i++) begin
            if (i == E_EP2A) continue;
            step(1'b0, 2'd0, 8'h00, 13'(1) << i);
            check_all("R2_R3");
        end
        // R4: writing zeros changes nothing
        step(1'b1, 2'd2, 8'h00, '0); check_all("R4");
        step(1'b1, 2'd3, 8'h00, '0); check_all("R4");
        // R4: clear selected bits only
        step(1'b1, 2'd2, 8'hA4, '0); check_all("R4");
        step(1'b1, 2'd3, 8'h24, '0); check_all("R4");
        // R6: writing the summary bit does not clear it
        step(1'b1, 2'd2, 8'h02, '0); check_all("R6");
        step(1'b1, 2'd3, 8'hFF, '0); check_all("R6");
        // R5: collision, set wins
        step(1'b1, 2'd2, 8'hFF, 13'(1) << E_SETUP); check_all("R5");
        step(1'b1, 2'd3, 8'h04, 13'(1) << E_SOF);   check_all("R5");
        step(1'b1, 2'd2, 8'hFF, '0); step(1'b1, 2'd3, 8'hFF, '0);
        // R8: reserved bits ignore writes
        step(1'b1, 2'd1, 8'hFF, '0); check_all("R8");
        step(1'b1, 2'd1, 8'h00, '0);
        // R12: EP2 qualification in both modes
        step(1'b0, 2'd0, 8'h00, 13'(1) << E_EP2T); check_all("R12");
        step(1'b0, 2'd0, 8'h00, (13'(1) << E_EP2T) | (13'(1) << E_EP2A)); check_all("R12");
        step(1'b1, 2'd2, 8'h20, '0);
        step(1'b1, 2'd1, 8'h01, '0); check_all("R11");
        step(1'b0, 2'd0, 8'h00, 13'(1) << E_EP2T); check_all("R12");
        // R9/R10: single enable routing for status 2
        step(1'b1, 2'd1, 8'h00, '0);
        step(1'b1, 2'd0, 8'h02, '0);
        step(1'b0, 2'd0, 8'h00, 13'(1) << E_RX); check_all("R9");
        step(1'b0, 2'd0, 8'h00, 13'(1) << E_TX); check_all("R10");
        step(1'b1, 2'd3, 8'h80, '0); check_all("R10");
        step(1'b1, 2'd1, 8'h10, '0);
        step(1'b0, 2'd0, 8'h00, 13'(1) << E_SOF); check_all("R9");
        step(1'b0, 2'd0, 8'h00, 13'(1) << E_SUSP); check_all("R9");
        step(1'b1, 2'd1, 8'h26, '0); check_all("R11");

        // R1: seeded random mix of events and register writes
        void'($urandom(32'd20240611));
        for (int n = 0; n < 600; n++) begin
            logic [12:0] e;
            logic w;
            e = '0;
            for (int b = 0; b < 13; b++) e[b] = (($urandom % 6) == 0);
            w = (($urandom % 3) == 0);
            step(w, 2'($urandom), 8'($urandom), e);
            check_all("R1");
        end

        // R7: reset in the middle of activity
        rst = 1'b1;
        @(posedge clk);
        m_en1 = 0; m_en2 = 0; m_s1 = 0; m_s2 = 0;
        @(negedge clk);
        rst = 1'b0;
        check_all("R7");
        finish_run();
    end
endmodule